// File: doc/BRIEF.md
# System Control Port with Alternate Reset Pulse

This block is an 8-bit control register that software reaches through a simple CPU I/O bus, at address 92h. It drives four system functions. A fixed-disk activity lamp lights while either of the two top bits is set. An A20 gate output copies bit 1. An active-low CPU reset is pulsed when software sets bit 0. Bit 3 works as a password lock: it hides the top slice of real-time-clock memory (indexes 36h through 3Fh) by removing the RTC read and write strobes whenever the selected index lies in that slice.

The port answers only while the external enable input is high. To decide whether an RTC access falls in the locked slice, the block watches every write to the RTC index port at 70h and keeps the low seven bits of the written byte. The RTC strobes pass through combinational gates, so an access outside the slice sees no added delay. The reset pulse is re-armed only after software writes bit 0 back to zero, so a loop that keeps writing 1 cannot hold the CPU in reset.

Top module: `sys_ctl_port`

## Requirements
- R1: After reset the register reads 24h, `disk_led` and `gate_a20` are 0 and `cpu_rst_n` is 1; a reset also clears bit 0.
- R2: A read or write is accepted only when `io_addr` equals 0092h and `port_en` is 1. A write at another address, or with `port_en` at 0, changes no output and no stored bit, and such a read returns 00h.
- R3: `disk_led` is 1 when stored bit 7 or bit 6 is 1, and 0 only when both are 0, from the clock edge that captures the write.
- R4: Bits 5 and 2 always read as 1 and bit 4 always reads as 0, whatever was written to them.
- R5: Bits 7, 6, 3, 1 and 0 read back the value last written. Bit 0 stays 1 during and after a reset pulse until software writes 0 to it.
- R6: `gate_a20` equals stored bit 1, from the clock edge that captures the write.
- R7: A write of 1 to bit 0 while the stored bit 0 is 0 drives `cpu_rst_n` low for exactly 4 clock cycles, starting at the capturing edge. After that it returns high.
- R8: A write of 1 to bit 0 while the stored bit 0 is already 1 produces no pulse. After bit 0 has been written to 0, a new write of 1 produces a new pulse.
- R9: With stored bit 3 at 1, `rtc_rd_out` and `rtc_wr_out` are held at 0 while the latched RTC index is in 36h..3Fh. The latched index is bits 6:0 of the last byte written to address 0070h; bit 7 of that byte is ignored.
- R10: When the latched index is outside 36h..3Fh, or stored bit 3 is 0, `rtc_rd_out` equals `rtc_rd_in` and `rtc_wr_out` equals `rtc_wr_in` in the same cycle.
- R11: `io_rdata` is 00h whenever `io_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high, sampled at each clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 00h when there is no read hit |
| port_en | input | 1 | External enable for the 92h port |
| rtc_rd_in | input | 1 | RTC read strobe from the bus decoder |
| rtc_wr_in | input | 1 | RTC write strobe from the bus decoder |
| rtc_rd_out | output | 1 | Gated RTC read strobe |
| rtc_wr_out | output | 1 | Gated RTC write strobe |
| disk_led | output | 1 | Fixed-disk activity lamp, active high |
| gate_a20 | output | 1 | A20 gate output |
| cpu_rst_n | output | 1 | Alternate CPU reset, active low |

## Verification
Read data and the gated RTC strobes are combinational. The bench therefore samples them 1 ns after driving the inputs, inside the same low clock phase. Register contents, `disk_led`, `gate_a20` and the index latch change at the rising edge that captures the write, so they are checked at the following falling edge. The reset pulse is sampled at four successive falling edges, starting with the one right after the capturing edge, and each sample must be low. At the fifth falling edge the output must be high again. The tests that expect no pulse watch six falling edges to confirm that `cpu_rst_n` stays high.

// File: rtl/xctl_pkg.sv
package xctl_pkg;
  localparam int CTL_W    = 8;
  localparam int B_LED_HI = 7;
  localparam int B_LED_LO = 6;
  localparam int B_LOCK   = 3;
  localparam int B_A20    = 1;
  localparam int B_RST    = 0;

  localparam logic [CTL_W-1:0] KEEP_MASK = 8'b1100_1011;
  localparam logic [CTL_W-1:0] ONES_MASK = 8'b0010_0100;

  function automatic logic [CTL_W-1:0] ctl_view(input logic [CTL_W-1:0] stored);
    return (stored & KEEP_MASK) | ONES_MASK;
  endfunction

  function automatic logic idx_in_slice(input logic [6:0] idx,
                                        input logic [6:0] lo,
                                        input logic [6:0] hi);
    return (idx >= lo) && (idx <= hi);
  endfunction
endpackage

// File: rtl/xctl_regfile.sv
module xctl_regfile
  import xctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] stored,
  output logic             fire_evt
);
  logic [CTL_W-1:0] stored_q;

  assign fire_evt = wr_hit && wdata[B_RST] && !stored_q[B_RST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q <= '0;
    end else if (wr_hit) begin
      stored_q <= wdata & KEEP_MASK;
    end
  end

  assign stored = stored_q;
endmodule

// File: rtl/xctl_rst_pulse.sv
module xctl_rst_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_n
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pulse_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pulse_n_q <= 1'b1;
    end else if (fire) begin
      cnt_q     <= CNT_W'(PULSE_CYC);
      pulse_n_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        pulse_n_q <= 1'b1;
      end
    end
  end

  assign pulse_n = pulse_n_q;
endmodule

// File: rtl/xctl_rtc_guard.sv
module xctl_rtc_guard
  import xctl_pkg::*;
#(
  parameter logic [6:0] LOCK_LO = 7'h36,
  parameter logic [6:0] LOCK_HI = 7'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [6:0] idx_wdata,
  input  logic       lock_en,
  input  logic       rd_in,
  input  logic       wr_in,
  output logic       rd_out,
  output logic       wr_out,
  output logic       blocked
);
  logic [6:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= idx_wdata;
    end
  end

  assign blocked = lock_en && idx_in_slice(idx_q, LOCK_LO, LOCK_HI);
  assign rd_out  = rd_in && !blocked;
  assign wr_out  = wr_in && !blocked;
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import xctl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CTL_ADDR  = 16'h0092,
  parameter logic [15:0] IDX_ADDR  = 16'h0070,
  parameter logic [6:0]  LOCK_LO   = 7'h36,
  parameter logic [6:0]  LOCK_HI   = 7'h3F,
  parameter int          PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              port_en,
  input  logic              rtc_rd_in,
  input  logic              rtc_wr_in,
  output logic              rtc_rd_out,
  output logic              rtc_wr_out,
  output logic              disk_led,
  output logic              gate_a20,
  output logic              cpu_rst_n
);
  logic             ctl_sel;
  logic             wr_hit;
  logic             rd_hit;
  logic             idx_wr;
  logic             fire_evt;
  logic             rtc_blocked;
  logic [CTL_W-1:0] stored;

  assign ctl_sel = (io_addr == ADDR_W'(CTL_ADDR)) && port_en;
  assign wr_hit  = ctl_sel && io_wr;
  assign rd_hit  = ctl_sel && io_rd;
  assign idx_wr  = (io_addr == ADDR_W'(IDX_ADDR)) && io_wr;

  xctl_regfile u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .wdata    (io_wdata),
    .stored   (stored),
    .fire_evt (fire_evt)
  );

  xctl_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire_evt),
    .pulse_n (cpu_rst_n)
  );

  xctl_rtc_guard #(.LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .idx_wdata (io_wdata[6:0]),
    .lock_en   (stored[B_LOCK]),
    .rd_in     (rtc_rd_in),
    .wr_in     (rtc_wr_in),
    .rd_out    (rtc_rd_out),
    .wr_out    (rtc_wr_out),
    .blocked   (rtc_blocked)
  );

  assign disk_led = stored[B_LED_HI] || stored[B_LED_LO];
  assign gate_a20 = stored[B_A20];
  assign io_rdata = rd_hit ? ctl_view(stored) : '0;
endmodule

// File: rtl/sys_ctl_port_chk.sv
module sys_ctl_port_chk #(
  parameter int PULSE_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       port_en,
  input logic       wr_hit,
  input logic       fire_evt,
  input logic       rtc_blocked,
  input logic       rtc_rd_in,
  input logic       rtc_wr_in,
  input logic       rtc_rd_out,
  input logic       rtc_wr_out,
  input logic       disk_led,
  input logic       gate_a20,
  input logic       cpu_rst_n
);
  logic [7:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                       low_run <= '0;
    else if (fire_evt)                low_run <= 8'd1;
    else if (!cpu_rst_n && low_run != 8'hFF) low_run <= low_run + 8'd1;
    else if (cpu_rst_n)               low_run <= '0;
  end

  a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> !cpu_rst_n);

  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> ($past(low_run) == 8'(PULSE_CYC)));

  a_r8_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && io_wdata[0] && !fire_evt && cpu_rst_n) |=> cpu_rst_n);

  a_r2_ignore_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !port_en && cpu_rst_n) |=> cpu_rst_n);

  a_r3_led: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (disk_led == ($past(io_wdata[7]) || $past(io_wdata[6]))));

  a_r6_a20: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (gate_a20 == $past(io_wdata[1])));

  a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_blocked |-> (!rtc_rd_out && !rtc_wr_out));

  a_r10_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_blocked |-> (rtc_rd_out == rtc_rd_in && rtc_wr_out == rtc_wr_in));

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));
endmodule

bind sys_ctl_port sys_ctl_port_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .port_en     (port_en),
  .wr_hit      (wr_hit),
  .fire_evt    (fire_evt),
  .rtc_blocked (rtc_blocked),
  .rtc_rd_in   (rtc_rd_in),
  .rtc_wr_in   (rtc_wr_in),
  .rtc_rd_out  (rtc_rd_out),
  .rtc_wr_out  (rtc_wr_out),
  .disk_led    (disk_led),
  .gate_a20    (gate_a20),
  .cpu_rst_n   (cpu_rst_n)
);

// File: tb/sys_ctl_port_tb.sv
module sys_ctl_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        port_en;
  logic        rtc_rd_in, rtc_wr_in;
  logic        rtc_rd_out, rtc_wr_out;
  logic        disk_led, gate_a20, cpu_rst_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sys_ctl_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .port_en(port_en),
    .rtc_rd_in(rtc_rd_in), .rtc_wr_in(rtc_wr_in),
    .rtc_rd_out(rtc_rd_out), .rtc_wr_out(rtc_wr_out),
    .disk_led(disk_led), .gate_a20(gate_a20), .cpu_rst_n(cpu_rst_n)
  );

  // {write byte, expected readback, expected lamp, expected A20}; bit 0 kept 0
  localparam logic [17:0] VEC [9] = '{
    {8'h00, 8'h24, 1'b0, 1'b0},
    {8'hFE, 8'hEE, 1'b1, 1'b1},
    {8'h80, 8'hA4, 1'b1, 1'b0},
    {8'h40, 8'h64, 1'b1, 1'b0},
    {8'h02, 8'h26, 1'b0, 1'b1},
    {8'h08, 8'h2C, 1'b0, 1'b0},
    {8'h34, 8'h24, 1'b0, 1'b0},
    {8'hC2, 8'hE6, 1'b1, 1'b1},
    {8'h10, 8'h24, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic expect_pulse(input string req);
    check(req, {7'd0, cpu_rst_n}, 8'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(req, {7'd0, cpu_rst_n}, 8'd0);
    end
    @(negedge clk);
    check(req, {7'd0, cpu_rst_n}, 8'd1);
  endtask

  task automatic expect_no_pulse(input string req);
    for (int i = 0; i < 6; i++) begin
      check(req, {7'd0, cpu_rst_n}, 8'd1);
      @(negedge clk);
    end
  endtask

  task automatic rtc_probe(input string req, input logic exp_pass);
    @(negedge clk);
    rtc_rd_in = 1'b1; rtc_wr_in = 1'b1;
    #1;
    check(req, {6'd0, rtc_rd_out, rtc_wr_out}, exp_pass ? 8'h03 : 8'h00);
    rtc_rd_in = 1'b0;
    #1;
    check(req, {6'd0, rtc_rd_out, rtc_wr_out}, exp_pass ? 8'h01 : 8'h00);
    rtc_wr_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0;
    port_en = 1'b1; rtc_rd_in = 0; rtc_wr_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 lamp", {7'd0, disk_led}, 8'd0);
    check("R1 a20", {7'd0, gate_a20}, 8'd0);
    check("R1 rst", {7'd0, cpu_rst_n}, 8'd1);
    io_read(16'h0092, rd); check("R1 readback", rd, 8'h24);

    // R3 R4 R5 R6 vector walk
    foreach (VEC[i]) begin
      io_write(16'h0092, VEC[i][17:10]);
      check("R3 lamp", {7'd0, disk_led}, {7'd0, VEC[i][1]});
      check("R6 a20", {7'd0, gate_a20}, {7'd0, VEC[i][0]});
      io_read(16'h0092, rd);
      check("R4/R5 readback", rd, VEC[i][9:2]);
    end

    // R2 disabled and wrong-address writes
    port_en = 1'b0;
    io_write(16'h0092, 8'hC3);
    check("R2 no pulse", {7'd0, cpu_rst_n}, 8'd1);
    check("R2 lamp", {7'd0, disk_led}, 8'd0);
    io_read(16'h0092, rd); check("R2 disabled read", rd, 8'h00);
    port_en = 1'b1;
    io_write(16'h0093, 8'hC3);
    check("R2 wrong addr", {6'd0, disk_led, gate_a20}, 8'd0);
    io_read(16'h0092, rd); check("R2 unchanged", rd, 8'h24);

    // R11 no strobe
    @(negedge clk); io_addr = 16'h0092; #1;
    check("R11 idle", io_rdata, 8'h00);

    // R7 pulse
    io_write(16'h0092, 8'h01);
    expect_pulse("R7 pulse");
    io_read(16'h0092, rd); check("R5 bit0 sticks", rd, 8'h25);

    // R8 rewrite 1 no pulse, then clear and set
    io_write(16'h0092, 8'h01);
    expect_no_pulse("R8 no refire");
    io_write(16'h0092, 8'h00);
    io_write(16'h0092, 8'h01);
    expect_pulse("R8 rearm");
    io_write(16'h0092, 8'h00);

    // R9 R10 RTC lock
    io_write(16'h0070, 8'h36);
    rtc_probe("R10 unlocked", 1'b1);
    io_write(16'h0092, 8'h08);
    rtc_probe("R9 idx36", 1'b0);
    io_write(16'h0070, 8'h3F); rtc_probe("R9 idx3F", 1'b0);
    io_write(16'h0070, 8'h35); rtc_probe("R10 idx35", 1'b1);
    io_write(16'h0070, 8'h40); rtc_probe("R10 idx40", 1'b1);
    io_write(16'h0070, 8'hB6); rtc_probe("R9 bit7 ignored", 1'b0);
    io_write(16'h0092, 8'h00); rtc_probe("R10 lock off", 1'b1);

    // R1 reset clears bit 0
    io_write(16'h0092, 8'hC3);
    repeat (6) @(negedge clk);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    io_read(16'h0092, rd); check("R1 bit0 cleared", rd, 8'h24);
    check("R1 rst high", {7'd0, cpu_rst_n}, 8'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule